// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit general register into a floating-point value for a float register. A two-bit type field tells it how to read the operand: as a signed or unsigned word taken from the low 32 bits, or as a signed or unsigned 64-bit value. A precision select picks the target. The value is either rounded to double precision, or rounded to single precision and then stored in double format. The caller supplies the rounding mode on each request.

Each request produces, one clock later, the 64-bit result, an inexact flag, a status-update enable and a 5-bit result class. A 4-bit condition field is also produced when the record bit is set. A 32-bit source converted to double always fits exactly, so that path deasserts the status-update enable. Internally the magnitude is normalised by a leading-zero count. It then goes through two rounders, one per target width, that share the normalised value.

Top module: `int2fp_cvt`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and carries that request's results. When `in_valid` is low, `out_valid` is low after the edge. While `rst_n` is low, `out_valid` and `result_o` are zero.
- R2: `src_type` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For types 0 and 1, bits 63:32 of `src_i` have no effect on any output.
- R3: With `single_sel` = 0 and a 32-bit type, the result is the exact double, `inexact_o` is 0 and `flags_upd_o` is 0.
- R4: With `single_sel` = 0 and a 64-bit type, the value is rounded to a 52-bit fraction. `inexact_o` is 1 exactly when nonzero bits were discarded, and `flags_upd_o` is 1.
- R5: With `single_sel` = 1, any type is rounded to a 23-bit fraction and widened to double format, so `result_o[28:0]` is zero. `flags_upd_o` is 1, and `inexact_o` reflects the bits lost at single precision.
- R6: `rnd_mode` encodes 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R7: When rounding up carries out of the fraction, the fraction becomes zero and the exponent rises by one. For example, unsigned 2^64-1 to nearest gives 0x43F0_0000_0000_0000, and 2^25-1 in single mode gives 0x4180_0000_0000_0000.
- R8: A zero value of the selected type gives +0.0 (all bits zero). Signed 64-bit 0x8000_0000_0000_0000 gives exactly -2^63 = 0xC3E0_0000_0000_0000.
- R9: `class_o` is 5'b00010 for +zero, 5'b00100 for a positive normal and 5'b01000 for a negative normal.
- R10: With `record_en` = 1, `cr_o` is {negative, positive, zero, 1'b0} of the result. With `record_en` = 0, `cr_o` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_i | input | 64 | Integer operand |
| src_type | input | 2 | Source integer type |
| single_sel | input | 1 | 1 = round to single precision |
| rnd_mode | input | 2 | Rounding mode |
| record_en | input | 1 | Produce the condition field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 64 | Double-format result |
| inexact_o | output | 1 | Rounding discarded nonzero bits |
| flags_upd_o | output | 1 | Status flags are to be updated |
| class_o | output | 5 | Result class |
| cr_o | output | 4 | Condition field |

## Verification
The interesting coincidence is a round-up that carries out of the fraction in the same cycle that the inexact flag rises. The fraction must collapse to zero while the exponent steps up, and the flag must still report the lost bits. The bench provokes this with all-ones magnitudes at both widths: 2^64-1 to double, and 2^25-1 to single. It also provokes it on ties rounded to even. A behavioural model computes each expected exponent, fraction and flag by comparing the remainder against the half-way point. A second overlap comes from issuing requests back to back with differing precision, type and mode. Each result is compared on the cycle it emerges, so a result that leaks from one request into the next is caught.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
   typedef enum logic [1:0] {
      IT_S32 = 2'd0,
      IT_U32 = 2'd1,
      IT_S64 = 2'd2,
      IT_U64 = 2'd3
   } i2f_itype_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_PINF = 2'd2,
      RM_NINF = 2'd3
   } i2f_rmode_e;

   localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
   localparam logic [4:0] CLS_POS_NORM = 5'b00100;
   localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
endpackage

// File: rtl/i2f_operand.sv
module i2f_operand
   import i2f_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src_i,
   input  logic [1:0]      type_i,
   output logic            sign_o,
   output logic [XLEN-1:0] mag_o,
   output logic            zero_o
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] ext;

   always_comb begin
      sign_o = 1'b0;
      ext    = src_i;
      unique case (i2f_itype_e'(type_i))
         IT_S32: begin
            sign_o = src_i[HALF-1];
            ext    = {{HALF{src_i[HALF-1]}}, src_i[HALF-1:0]};
         end
         IT_U32: ext = {{HALF{1'b0}}, src_i[HALF-1:0]};
         IT_S64: sign_o = src_i[XLEN-1];
         default: ext = src_i;
      endcase
      mag_o  = sign_o ? (~ext + 1'b1) : ext;
      zero_o = (mag_o == '0);
   end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
   parameter int XLEN  = 64,
   localparam int CNT_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]  vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < XLEN; i++) begin
         if (vec_i[i]) cnt_o = CNT_W'(XLEN - 1 - i);
      end
   end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
   import i2f_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int FRAC_W = 52,
   parameter int EXP_W  = 11,
   parameter int BIAS   = 1023,
   localparam int CNT_W = $clog2(XLEN),
   localparam int KEEP_W = FRAC_W + 1
) (
   input  logic [XLEN-1:0]   norm_i,
   input  logic [CNT_W-1:0]  exp_unb_i,
   input  logic              sign_i,
   input  logic              zero_i,
   input  logic [1:0]        rmode_i,
   output logic [EXP_W-1:0]  exp_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic              inexact_o
);
   logic [KEEP_W-1:0] kept;
   logic              guard, sticky, inc, carry;
   logic [KEEP_W:0]   sum;

   assign kept   = norm_i[XLEN-1 -: KEEP_W];
   assign guard  = norm_i[XLEN-2-FRAC_W];
   assign sticky = |norm_i[XLEN-3-FRAC_W:0];

   always_comb begin
      unique case (i2f_rmode_e'(rmode_i))
         RM_NEAR: inc = guard & (sticky | kept[0]);
         RM_ZERO: inc = 1'b0;
         RM_PINF: inc = (guard | sticky) & ~sign_i;
         default: inc = (guard | sticky) & sign_i;
      endcase
   end

   assign sum       = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
   assign carry     = sum[KEEP_W];
   assign inexact_o = guard | sticky;
   assign frac_o    = carry ? '0 : sum[FRAC_W-1:0];
   assign exp_o     = zero_i ? '0 :
                      (EXP_W'(BIAS) + EXP_W'(exp_unb_i) + EXP_W'(carry));
endmodule

// File: rtl/int2fp_cvt.sv
module int2fp_cvt
   import i2f_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int EXP_W    = 11,
   parameter int DBL_FRAC = 52,
   parameter int SGL_FRAC = 23,
   parameter int BIAS     = 1023,
   localparam int CNT_W   = $clog2(XLEN),
   localparam int PAD_W   = DBL_FRAC - SGL_FRAC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [63:0]     src_i,
   input  logic [1:0]      src_type,
   input  logic            single_sel,
   input  logic [1:0]      rnd_mode,
   input  logic            record_en,
   output logic            out_valid,
   output logic [63:0]     result_o,
   output logic            inexact_o,
   output logic            flags_upd_o,
   output logic [4:0]      class_o,
   output logic [3:0]      cr_o
);
   if (XLEN != 64) begin : g_bad_xlen
      $error("int2fp_cvt: XLEN must be 64");
   end
   if (SGL_FRAC >= DBL_FRAC) begin : g_bad_frac
      $error("int2fp_cvt: single fraction must be narrower than double");
   end
   if (DBL_FRAC + 3 > XLEN) begin : g_bad_room
      $error("int2fp_cvt: no room for guard and sticky bits");
   end
   if (1 + EXP_W + DBL_FRAC != 64) begin : g_bad_fmt
      $error("int2fp_cvt: result format must be 64 bits wide");
   end

   logic              sign, zero;
   logic [XLEN-1:0]   mag, norm;
   logic [CNT_W-1:0]  lz, exp_unb;
   logic [EXP_W-1:0]  exp_d, exp_s, exp_sel;
   logic [DBL_FRAC-1:0] frac_d, frac_sel;
   logic [SGL_FRAC-1:0] frac_s;
   logic [DBL_FRAC-1:0] frac_s_wide;
   logic              inx_d, inx_s, inx_sel, upd_sel;
   logic [63:0]       res_c;
   logic [4:0]        cls_c;
   logic [3:0]        cr_c;

   i2f_operand #(.XLEN(XLEN)) u_opnd (
      .src_i  (src_i),
      .type_i (src_type),
      .sign_o (sign),
      .mag_o  (mag),
      .zero_o (zero)
   );

   i2f_lzc #(.XLEN(XLEN)) u_lzc (
      .vec_i (mag),
      .cnt_o (lz)
   );

   assign norm    = mag << lz;
   assign exp_unb = CNT_W'(XLEN - 1) - lz;

   i2f_round #(.XLEN(XLEN), .FRAC_W(DBL_FRAC), .EXP_W(EXP_W), .BIAS(BIAS)) u_rnd_dbl (
      .norm_i    (norm),
      .exp_unb_i (exp_unb),
      .sign_i    (sign),
      .zero_i    (zero),
      .rmode_i   (rnd_mode),
      .exp_o     (exp_d),
      .frac_o    (frac_d),
      .inexact_o (inx_d)
   );

   i2f_round #(.XLEN(XLEN), .FRAC_W(SGL_FRAC), .EXP_W(EXP_W), .BIAS(BIAS)) u_rnd_sgl (
      .norm_i    (norm),
      .exp_unb_i (exp_unb),
      .sign_i    (sign),
      .zero_i    (zero),
      .rmode_i   (rnd_mode),
      .exp_o     (exp_s),
      .frac_o    (frac_s),
      .inexact_o (inx_s)
   );

   if (PAD_W > 0) begin : g_widen_pad
      assign frac_s_wide = {frac_s, {PAD_W{1'b0}}};
   end else begin : g_widen_none
      assign frac_s_wide = frac_s;
   end

   always_comb begin
      exp_sel  = single_sel ? exp_s : exp_d;
      frac_sel = single_sel ? frac_s_wide : frac_d;
      upd_sel  = single_sel | src_type[1];
      inx_sel  = single_sel ? inx_s : (inx_d & src_type[1]);
      res_c    = {sign & ~zero, exp_sel, frac_sel};
      if (zero)      cls_c = CLS_POS_ZERO;
      else if (sign) cls_c = CLS_NEG_NORM;
      else           cls_c = CLS_POS_NORM;
      cr_c = record_en ? {sign & ~zero, ~sign & ~zero, zero, 1'b0} : 4'b0000;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         result_o    <= '0;
         inexact_o   <= 1'b0;
         flags_upd_o <= 1'b0;
         class_o     <= '0;
         cr_o        <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result_o    <= res_c;
            inexact_o   <= inx_sel;
            flags_upd_o <= upd_sel;
            class_o     <= cls_c;
            cr_o        <= cr_c;
         end
      end
   end
endmodule

// File: rtl/int2fp_cvt_chk.sv
module int2fp_cvt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [63:0] src_i,
   input logic [1:0]  src_type,
   input logic        single_sel,
   input logic        record_en,
   input logic        out_valid,
   input logic [63:0] result_o,
   input logic        inexact_o,
   input logic        flags_upd_o,
   input logic [4:0]  class_o,
   input logic [3:0]  cr_o
);
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_WORD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !single_sel && !src_type[1] |=> !inexact_o && !flags_upd_o); // R3
   AST_WIDE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && src_type[1] |=> flags_upd_o); // R4
   AST_SINGLE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && single_sel |=> result_o[28:0] == 29'd0 && flags_upd_o); // R5
   AST_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && src_i == 64'd0 |=> result_o == 64'd0); // R8
   AST_CLASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot(class_o[3:1]) && class_o[4] == 1'b0 && class_o[0] == 1'b0); // R9
   AST_CR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !record_en |=> cr_o == 4'b0000); // R10
endmodule

bind int2fp_cvt int2fp_cvt_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .src_i       (src_i),
   .src_type    (src_type),
   .single_sel  (single_sel),
   .record_en   (record_en),
   .out_valid   (out_valid),
   .result_o    (result_o),
   .inexact_o   (inexact_o),
   .flags_upd_o (flags_upd_o),
   .class_o     (class_o),
   .cr_o        (cr_o)
);

// File: tb/sim_int2fp_cvt.sv
module sim_int2fp_cvt;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_i = '0;
   logic [1:0]  src_type = '0;
   logic        single_sel = 1'b0;
   logic [1:0]  rnd_mode = '0;
   logic        record_en = 1'b0;
   logic        out_valid;
   logic [63:0] result_o;
   logic        inexact_o;
   logic        flags_upd_o;
   logic [4:0]  class_o;
   logic [3:0]  cr_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [63:0] res;
      logic        inx;
      logic        upd;
      logic [4:0]  cls;
      logic [3:0]  cr;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   logic  prev_valid = 1'b0;
   logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

   always #(CLK_PERIOD / 2) clk = ~clk;

   int2fp_cvt u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_i(src_i),
      .src_type(src_type), .single_sel(single_sel), .rnd_mode(rnd_mode),
      .record_en(record_en), .out_valid(out_valid), .result_o(result_o),
      .inexact_o(inexact_o), .flags_upd_o(flags_upd_o), .class_o(class_o),
      .cr_o(cr_o)
   );

   function automatic exp_t ref_conv(logic [63:0] s, logic [1:0] t, logic sg,
                                     logic [1:0] rm, logic rec);
      exp_t        r;
      longint      sv;
      logic        neg;
      logic [63:0] mag;
      logic [64:0] kept, rem, half, frw;
      logic        up;
      int          msb, p, sh, e;
      logic [51:0] fr;
      neg = 1'b0;
      case (t)
         2'd0: begin sv = longint'(int'(s[31:0])); neg = sv < 0; mag = neg ? 64'(-sv) : 64'(sv); end
         2'd1: mag = {32'd0, s[31:0]};
         2'd2: begin sv = longint'(s); neg = sv < 0; mag = neg ? 64'(-sv) : s; end
         default: mag = s;
      endcase
      p = sg ? 23 : 52;
      msb = -1;
      for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
      r.inx = 1'b0;
      if (msb < 0) begin
         r.res = 64'd0;
      end else begin
         e = msb;
         if (msb <= p) begin
            kept = 65'(mag) << (p - msb);
         end else begin
            sh   = msb - p;
            kept = 65'(mag) >> sh;
            rem  = 65'(mag) & ((65'd1 << sh) - 65'd1);
            half = 65'd1 << (sh - 1);
            r.inx = (rem != 0);
            case (rm)
               2'd0: up = (rem > half) || (rem == half && kept[0]);
               2'd1: up = 1'b0;
               2'd2: up = r.inx && !neg;
               default: up = r.inx && neg;
            endcase
            kept = kept + 65'(up);
            if (kept[p+1]) begin
               kept = kept >> 1;
               e = e + 1;
            end
         end
         frw = kept & ((65'd1 << p) - 65'd1);
         fr  = 52'(frw) << (52 - p);
         r.res = {neg, 11'(e + 1023), fr};
      end
      if (!sg && !t[1]) r.inx = 1'b0;
      r.upd = sg | t[1];
      if (msb < 0)  r.cls = 5'b00010;
      else if (neg) r.cls = 5'b01000;
      else          r.cls = 5'b00100;
      r.cr = rec ? {neg && msb >= 0, !neg && msb >= 0, msb < 0, 1'b0} : 4'b0000;
      return r;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic observe();
      exp_t  e;
      string tg;
      check(out_valid == prev_valid, "R1", "out_valid", 64'(out_valid), 64'(prev_valid));
      if (out_valid && exp_q.size() > 0) begin
         e  = exp_q.pop_front();
         tg = tag_q.pop_front();
         check(result_o == e.res, tg, "result", result_o, e.res);
         check(inexact_o == e.inx, tg, "inexact", 64'(inexact_o), 64'(e.inx));
         check(flags_upd_o == e.upd, tg, "flags_upd", 64'(flags_upd_o), 64'(e.upd));
         check(class_o == e.cls, "R9", "class", 64'(class_o), 64'(e.cls));
         check(cr_o == e.cr, "R10", "cr", 64'(cr_o), 64'(e.cr));
      end
   endtask

   task automatic step(logic v, logic [63:0] s, logic [1:0] t, logic sg,
                       logic [1:0] rm, logic rec, string tag);
      @(negedge clk);
      observe();
      in_valid = v; src_i = s; src_type = t; single_sel = sg;
      rnd_mode = rm; record_en = rec;
      prev_valid = v;
      if (v) begin
         exp_q.push_back(ref_conv(s, t, sg, rm, rec));
         tag_q.push_back(tag);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "reset valid", 64'(out_valid), 64'd0);
      check(result_o == 64'd0, "R1", "reset result", result_o, 64'd0);
      rst_n = 1'b1;
      // R8 zero and most negative 64-bit value
      step(1, 64'd0, 2'd2, 0, 2'd0, 1, "R8");
      step(1, 64'h8000_0000_0000_0000, 2'd2, 0, 2'd0, 1, "R8");
      // R3 exact word paths, R2 upper bits ignored
      step(1, 64'd1, 2'd0, 0, 2'd0, 1, "R3");
      step(1, 64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 0, 2'd3, 1, "R2");
      step(1, 64'h1234_5678_FFFF_FFFF, 2'd1, 0, 2'd0, 0, "R2");
      step(1, 64'hFFFF_FFFF_0000_0000, 2'd1, 0, 2'd0, 1, "R2");
      step(0, 64'd0, 2'd0, 0, 2'd0, 0, "R1");
      // R7 carry out of the fraction together with inexact
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd0, 1, "R7");
      step(1, 64'h0000_0000_01FF_FFFF, 2'd0, 1, 2'd0, 1, "R7");
      // R4 ties and modes on 64-bit sources, R6 mode encodings
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd1, 0, "R4");
      step(1, 64'h0020_0000_0000_0001, 2'd2, 0, 2'd0, 1, "R4");
      step(1, 64'h0020_0000_0000_0001, 2'd2, 0, 2'd2, 1, "R6");
      step(1, 64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd3, 1, "R6");
      step(1, 64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd2, 1, "R6");
      // R5 single precision from every type
      step(1, 64'd16777217, 2'd0, 1, 2'd0, 1, "R5");
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1, 2'd2, 1, "R5");
      step(1, 64'h8000_0000_0000_0001, 2'd2, 1, 2'd3, 1, "R5");
      step(1, 64'd0, 2'd3, 1, 2'd1, 1, "R5");
      // R6 random sweep, back to back and with gaps
      for (int n = 0; n < 3000; n++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 7);
         lfsr = lfsr ^ (lfsr << 17);
         step(lfsr[0] | lfsr[1], lfsr >> lfsr[63:58], lfsr[3:2], lfsr[4],
              lfsr[6:5], lfsr[7], "R6");
      end
      step(0, 64'd0, 2'd0, 0, 2'd0, 0, "R1");
      step(0, 64'd0, 2'd0, 0, 2'd0, 0, "R1");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule